// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder with Drive Protection

This block sits between the Hall sensors of a brushless DC motor and the gate drivers of its power stage. It resynchronises the three sensor lines, decodes the rotor position into one active high-side switch and one active low-side switch, and applies protection before the six drive levels reach the pins. The analog parts of the motor controller are outside the block. Its comparators deliver enable, overcurrent and the PWM gate as synchronous logic flags.

Three decode modes are available. With three sensors, the spacing is either 120° or 60° electrical. In the four-phase mode, two sensors sit 90° apart and the second sensor is wired to both the second and third sensor inputs. The outputs are gated in a fixed order of priority. Brake comes first. Next come enable, invalid code and reversal blanking. Overcurrent follows, and PWM gating is applied last. The top-driver polarity is chosen at the last stage.

Top module: `bldc_commutator`

## Requirements
- R1: With `spacing_60`=0 and `quad_mode`=0, `dir_fwd`=1, the sensor code `hall_in[2:0]` selects the active top and bottom phase, each given as a one-hot vector (bit0=A, bit1=B, bit2=C; `drv_top[0]`/`drv_bot[0]` belong to phase A). The mapping is: 001→top A/bottom B, 011→A/C, 010→B/C, 110→B/A, 100→C/A, 101→C/B. No phase ever has its top and bottom active together outside four-phase mode.
- R2: With `spacing_60`=1 and `dir_fwd`=1, the mapping is: 000→B/C, 001→A/C, 011→A/B, 111→C/B, 110→C/A, 100→B/A.
- R3: Some codes are invalid. In 120° mode these are 000 and 111. In 60° mode they are 010 and 101. In four-phase mode, any code with `hall_in[1]`≠`hall_in[0]` is invalid. An invalid code turns all six drivers off and raises `fault`.
- R4: In three-phase modes, `dir_fwd`=0 swaps the top and bottom phase of every entry.
- R5: When `dir_fwd` differs from its value at the previous clock edge, all drivers are off for exactly 2 cycles, and then commutation resumes.
- R6: Four-phase mode (`quad_mode`=1, `dir_fwd`=1) uses only outputs 1, 3, 4 and 6. It maps {`hall_in[2]`,`hall_in[1]`} as: 00→top A/bottom C, 01→C/C, 11→C/A, 10→A/A. With `dir_fwd`=0, it uses the entry of the inverted two-bit state.
- R7: `enable`=0 turns all drivers off and raises `fault`.
- R8: `brake`=1 overrides every other input and turns all top drivers off. With `brake_full`=1, all bottom drivers are on.
- R9: With `brake`=1 and `brake_full`=0, all three bottom drivers equal `pwm_gate`.
- R10: `overcurrent`=1 raises `fault`. It turns all drivers off when the parameter `OC_ALL_OFF`=1. When `OC_ALL_OFF`=0, it turns off only the bottom drivers and leaves the top drivers working normally.
- R11: With `top_pol_high`=1, an active top driver is high. With `top_pol_high`=0, each top output is inverted, so an active top driver is low. Bottom drivers are always active-high.
- R12: `pwm_gate` gates the bottom drivers at all times. It gates the top drivers only when `pwm_bottom_only`=0.
- R13: The outputs are registered. A sensor change reaches the outputs on the third rising edge after it is applied, and a control input reaches them on the next edge. In reset, all drivers are off and `fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Raw Hall sensor levels, asynchronous |
| dir_fwd | input | 1 | 1 = forward rotation, 0 = reverse |
| spacing_60 | input | 1 | 1 = 60° sensor spacing, 0 = 120° |
| quad_mode | input | 1 | 1 = four-phase decode |
| enable | input | 1 | 0 = all drivers off, fault |
| brake | input | 1 | Brake request, highest priority |
| brake_full | input | 1 | 1 = unconditional brake, 0 = PWM brake |
| top_pol_high | input | 1 | Active level of the top drivers |
| overcurrent | input | 1 | Overcurrent flag from the current comparator |
| pwm_gate | input | 1 | PWM on/off from the PWM comparator |
| pwm_bottom_only | input | 1 | 1 = PWM on bottom drivers only |
| drv_top | output | 3 | High-side drive levels, phases C..A |
| drv_bot | output | 3 | Low-side drive levels, phases C..A |
| fault | output | 1 | Fault indication |

## Verification
The sensor codes are stepped through all eight values in each spacing mode, in both directions and in four-phase mode. This separates a wrong table entry from a wrong reversal rule and from wrong invalid-code detection. Codes are also changed on every clock, which exposes any error in the synchroniser depth. Single and double direction flips check that the blank window is exactly two cycles long and restarts when a second flip arrives. The control tests put brake against enable low, an invalid code and overcurrent, and toggle the PWM gate each cycle under both routing choices and both polarities. Two instances with different overcurrent scopes run side by side to separate the full mask from the bottom-only mask.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

    localparam logic [2:0] PH_A = 3'b001;
    localparam logic [2:0] PH_B = 3'b010;
    localparam logic [2:0] PH_C = 3'b100;
    localparam logic [2:0] PH_NONE = 3'b000;

    typedef struct packed {
        logic       valid;
        logic [2:0] top;
        logic [2:0] bot;
    } phase_pair_t;

    // Six-step table in 120-degree code space, forward rotation.
    function automatic phase_pair_t sixstep(input logic [2:0] code);
        phase_pair_t p;
        p.valid = 1'b1;
        unique case (code)
            3'b001: begin p.top = PH_A; p.bot = PH_B; end
            3'b011: begin p.top = PH_A; p.bot = PH_C; end
            3'b010: begin p.top = PH_B; p.bot = PH_C; end
            3'b110: begin p.top = PH_B; p.bot = PH_A; end
            3'b100: begin p.top = PH_C; p.bot = PH_A; end
            3'b101: begin p.top = PH_C; p.bot = PH_B; end
            default: begin p.valid = 1'b0; p.top = PH_NONE; p.bot = PH_NONE; end
        endcase
        return p;
    endfunction

    function automatic logic [2:0] mirror_ac(input logic [2:0] v);
        return {v[0], v[1], v[2]};
    endfunction

    // Two-sensor table: state {s1,s2}; reverse takes the opposite state.
    function automatic phase_pair_t quadstep(input logic [1:0] st);
        phase_pair_t p;
        p.valid = 1'b1;
        unique case (st)
            2'b00: begin p.top = PH_A; p.bot = PH_C; end
            2'b01: begin p.top = PH_C; p.bot = PH_C; end
            2'b11: begin p.top = PH_C; p.bot = PH_A; end
            default: begin p.top = PH_A; p.bot = PH_A; end
        endcase
        return p;
    endfunction

    function automatic phase_pair_t decode_hall(input logic [2:0] h,
                                                input logic       sp60,
                                                input logic       quad,
                                                input logic       fwd);
        phase_pair_t p;
        if (quad) begin
            p = quadstep(fwd ? h[2:1] : ~h[2:1]);
            p.valid = (h[1] == h[0]);
            if (!p.valid) begin
                p.top = PH_NONE;
                p.bot = PH_NONE;
            end
        end else begin
            // 60-degree codes map onto 120-degree space by flipping the middle sensor
            p = sixstep(sp60 ? (h ^ 3'b010) : h);
            if (!fwd) p = '{valid: p.valid, top: p.bot, bot: p.top};
        end
        return p;
    endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/reversal_blanker.sv
module reversal_blanker #(
    parameter int BLANK_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_fwd,
    output logic blank
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYCLES - 1);

    logic          dir_q;
    logic [CW-1:0] remain;
    logic          flipped;

    assign flipped = (dir_fwd != dir_q);
    assign blank   = flipped || (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= dir_fwd;
            remain <= '0;
        end else begin
            dir_q <= dir_fwd;
            if (flipped)             remain <= RELOAD;
            else if (remain != '0)   remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/drive_mux.sv
module drive_mux
    import bldc_comm_pkg::*;
#(
    parameter bit OC_ALL_OFF = 1'b1
) (
    input  phase_pair_t pair,
    input  logic        blank,
    input  logic        enable,
    input  logic        brake,
    input  logic        brake_full,
    input  logic        overcurrent,
    input  logic        pwm_gate,
    input  logic        pwm_bottom_only,
    input  logic        top_pol_high,
    output logic [2:0]  top_lvl,
    output logic [2:0]  bot_lvl,
    output logic        fault_now
);
    logic [2:0] oc_top_keep;
    logic [2:0] top_act;
    logic [2:0] bot_act;

    if (OC_ALL_OFF) begin : g_oc_all
        assign oc_top_keep = 3'b000;
    end else begin : g_oc_bottom
        assign oc_top_keep = 3'b111;
    end

    always_comb begin
        top_act = '0;
        bot_act = '0;
        if (brake) begin
            bot_act = brake_full ? 3'b111 : {3{pwm_gate}};
        end else if (enable && pair.valid && !blank) begin
            top_act = pair.top & {3{pwm_gate | pwm_bottom_only}};
            bot_act = pair.bot & {3{pwm_gate}};
            if (overcurrent) begin
                bot_act = '0;
                top_act = top_act & oc_top_keep;
            end
        end
    end

    assign top_lvl   = top_pol_high ? top_act : ~top_act;
    assign bot_lvl   = bot_act;
    assign fault_now = !enable || !pair.valid || overcurrent;
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_comm_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 2,
    parameter bit OC_ALL_OFF   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_fwd,
    input  logic       spacing_60,
    input  logic       quad_mode,
    input  logic       enable,
    input  logic       brake,
    input  logic       brake_full,
    input  logic       top_pol_high,
    input  logic       overcurrent,
    input  logic       pwm_gate,
    input  logic       pwm_bottom_only,
    output logic [2:0] drv_top,
    output logic [2:0] drv_bot,
    output logic       fault
);
    logic [2:0]  hall_q;
    logic        blank;
    phase_pair_t pair;
    logic [2:0]  top_lvl;
    logic [2:0]  bot_lvl;
    logic        fault_now;

    hall_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (hall_in),
        .dout (hall_q)
    );

    reversal_blanker #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .dir_fwd (dir_fwd),
        .blank   (blank)
    );

    assign pair = decode_hall(hall_q, spacing_60, quad_mode, dir_fwd);

    drive_mux #(.OC_ALL_OFF(OC_ALL_OFF)) u_mux (
        .pair            (pair),
        .blank           (blank),
        .enable          (enable),
        .brake           (brake),
        .brake_full      (brake_full),
        .overcurrent     (overcurrent),
        .pwm_gate        (pwm_gate),
        .pwm_bottom_only (pwm_bottom_only),
        .top_pol_high    (top_pol_high),
        .top_lvl         (top_lvl),
        .bot_lvl         (bot_lvl),
        .fault_now       (fault_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_top <= {3{~top_pol_high}};
            drv_bot <= '0;
            fault   <= 1'b0;
        end else begin
            drv_top <= top_lvl;
            drv_bot <= bot_lvl;
            fault   <= fault_now;
        end
    end
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic       dir_fwd,
    input logic       quad_mode,
    input logic       enable,
    input logic       brake,
    input logic       brake_full,
    input logic       top_pol_high,
    input logic       overcurrent,
    input logic [2:0] drv_top,
    input logic [2:0] drv_bot,
    input logic       fault
);
    logic [2:0] top_act;
    assign top_act = top_pol_high ? drv_top : ~drv_top;

    // R1
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(quad_mode) && $stable(top_pol_high)) |-> ((top_act & drv_bot) == 3'b000));

    // R1
    single_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(brake) |-> ($countones(drv_bot) <= 1));

    // R8
    brake_top_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(brake) && $stable(top_pol_high)) |-> (top_act == 3'b000));

    // R8
    brake_full_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(brake && brake_full && !rst)) |-> (drv_bot == 3'b111));

    // R7
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!enable && !brake && !rst) && $stable(top_pol_high))
            |-> (drv_bot == 3'b000 && top_act == 3'b000 && fault));

    // R5
    reversal_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(brake) && ($past(dir_fwd) != $past(dir_fwd, 2))
            && $stable(top_pol_high)) |-> (drv_bot == 3'b000 && top_act == 3'b000));

    // R10
    oc_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $past(overcurrent && !rst) |-> fault);
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dir_fwd      (dir_fwd),
    .quad_mode    (quad_mode),
    .enable       (enable),
    .brake        (brake),
    .brake_full   (brake_full),
    .top_pol_high (top_pol_high),
    .overcurrent  (overcurrent),
    .drv_top      (drv_top),
    .drv_bot      (drv_bot),
    .fault        (fault)
);

// File: tb/tb_bldc_commutator.sv
module tb_bldc_commutator;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] hall_in = 3'b000;
    logic dir_fwd = 1'b1, spacing_60 = 1'b0, quad_mode = 1'b0, enable = 1'b1;
    logic brake = 1'b0, brake_full = 1'b1, top_pol_high = 1'b1, overcurrent = 1'b0;
    logic pwm_gate = 1'b1, pwm_bottom_only = 1'b0;
    logic [2:0] drv_top, drv_bot, drv_top_b, drv_bot_b;
    logic fault, fault_b;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [2:0] m_s1 = 3'b000, m_s2 = 3'b000;
    logic       m_dprev = 1'b1;
    int         m_bcnt = 0;
    logic [2:0] e_top, e_bot, e_top_b, e_bot_b;
    logic       e_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    bldc_commutator #(.OC_ALL_OFF(1'b1)) dut (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_fwd(dir_fwd),
        .spacing_60(spacing_60), .quad_mode(quad_mode), .enable(enable),
        .brake(brake), .brake_full(brake_full), .top_pol_high(top_pol_high),
        .overcurrent(overcurrent), .pwm_gate(pwm_gate),
        .pwm_bottom_only(pwm_bottom_only),
        .drv_top(drv_top), .drv_bot(drv_bot), .fault(fault));

    bldc_commutator #(.OC_ALL_OFF(1'b0)) dut_bot (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_fwd(dir_fwd),
        .spacing_60(spacing_60), .quad_mode(quad_mode), .enable(enable),
        .brake(brake), .brake_full(brake_full), .top_pol_high(top_pol_high),
        .overcurrent(overcurrent), .pwm_gate(pwm_gate),
        .pwm_bottom_only(pwm_bottom_only),
        .drv_top(drv_top_b), .drv_bot(drv_bot_b), .fault(fault_b));

    // returns {valid, top[2:0], bot[2:0]}; A=001 B=010 C=100
    function automatic logic [6:0] ref_pair(logic [2:0] h, logic sp60, logic quad, logic fwd);
        logic [2:0] t, b;
        logic [1:0] st;
        logic v;
        v = 1'b1; t = 3'b000; b = 3'b000;
        if (quad) begin
            st = fwd ? h[2:1] : (h[2:1] ^ 2'b11);
            case (st)
                2'b00: begin t = 3'b001; b = 3'b100; end
                2'b01: begin t = 3'b100; b = 3'b100; end
                2'b11: begin t = 3'b100; b = 3'b001; end
                default: begin t = 3'b001; b = 3'b001; end
            endcase
            if (h[1] != h[0]) begin v = 1'b0; t = 3'b000; b = 3'b000; end
            return {v, t, b};
        end
        if (sp60) begin
            case (h)
                3'b000: begin t = 3'b010; b = 3'b100; end
                3'b001: begin t = 3'b001; b = 3'b100; end
                3'b011: begin t = 3'b001; b = 3'b010; end
                3'b111: begin t = 3'b100; b = 3'b010; end
                3'b110: begin t = 3'b100; b = 3'b001; end
                3'b100: begin t = 3'b010; b = 3'b001; end
                default: v = 1'b0;
            endcase
        end else begin
            case (h)
                3'b001: begin t = 3'b001; b = 3'b010; end
                3'b011: begin t = 3'b001; b = 3'b100; end
                3'b010: begin t = 3'b010; b = 3'b100; end
                3'b110: begin t = 3'b010; b = 3'b001; end
                3'b100: begin t = 3'b100; b = 3'b001; end
                3'b101: begin t = 3'b100; b = 3'b010; end
                default: v = 1'b0;
            endcase
        end
        if (fwd) return {v, t, b};
        return {v, b, t};
    endfunction

    task automatic model_step();
        logic [6:0] p;
        logic blank;
        logic [2:0] ta, ba, ta_b, ba_b;
        if (rst) begin
            m_s1 = 3'b000; m_s2 = 3'b000; m_dprev = dir_fwd; m_bcnt = 0;
            e_top = {3{~top_pol_high}}; e_bot = 3'b000;
            e_top_b = e_top; e_bot_b = 3'b000; e_fault = 1'b0;
            return;
        end
        blank = (dir_fwd != m_dprev) || (m_bcnt != 0);
        if (dir_fwd != m_dprev) m_bcnt = 1;
        else if (m_bcnt > 0)    m_bcnt = m_bcnt - 1;
        m_dprev = dir_fwd;
        p = ref_pair(m_s2, spacing_60, quad_mode, dir_fwd);
        ta = 3'b000; ba = 3'b000; ta_b = 3'b000; ba_b = 3'b000;
        if (brake) begin
            ba = brake_full ? 3'b111 : (pwm_gate ? 3'b111 : 3'b000);
            ba_b = ba;
        end else if (enable && p[6] && !blank) begin
            ta = (pwm_gate || pwm_bottom_only) ? p[5:3] : 3'b000;
            ba = pwm_gate ? p[2:0] : 3'b000;
            ta_b = ta; ba_b = ba;
            if (overcurrent) begin
                ta = 3'b000; ba = 3'b000; ba_b = 3'b000;
            end
        end
        e_top   = top_pol_high ? ta : ~ta;
        e_top_b = top_pol_high ? ta_b : ~ta_b;
        e_bot   = ba;
        e_bot_b = ba_b;
        e_fault = !enable || !p[6] || overcurrent;
        m_s2 = m_s1;
        m_s1 = hall_in;
    endtask

    task automatic compare(string tg);
        checks++;
        if (drv_top !== e_top || drv_bot !== e_bot || fault !== e_fault) begin
            fails++;
            $display("FAIL %s full-mask: got top=%b bot=%b fault=%b expected top=%b bot=%b fault=%b",
                     tg, drv_top, drv_bot, fault, e_top, e_bot, e_fault);
        end
        checks++;
        if (drv_top_b !== e_top_b || drv_bot_b !== e_bot_b || fault_b !== e_fault) begin
            fails++;
            $display("FAIL %s bottom-mask: got top=%b bot=%b fault=%b expected top=%b bot=%b fault=%b",
                     tg, drv_top_b, drv_bot_b, fault_b, e_top_b, e_bot_b, e_fault);
        end
    endtask

    task automatic tick(string tg);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tg);
    endtask

    task automatic hold(logic [2:0] h, int n, string tg);
        hall_in = h;
        for (int i = 0; i < n; i++) tick(tg);
    endtask

    task automatic sweep(string tg);
        for (int c = 0; c < 8; c++) hold(3'(c), 4, tg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R13 reset state, both polarities
        tick("R13");
        top_pol_high = 1'b0; tick("R13");
        top_pol_high = 1'b1; tick("R13");
        rst = 1'b0;

        // R1 forward 120-degree sequence, R3 invalid codes
        hold(3'b001, 4, "R1"); hold(3'b011, 4, "R1"); hold(3'b010, 4, "R1");
        hold(3'b110, 4, "R1"); hold(3'b100, 4, "R1"); hold(3'b101, 4, "R1");
        hold(3'b000, 4, "R3"); hold(3'b111, 4, "R3");

        // R13 latency: code changes every cycle
        for (int i = 0; i < 12; i++) begin
            hall_in = (i % 2 == 0) ? 3'b011 : 3'b110;
            tick("R13");
        end

        // R4 reverse table, R5 blanking at the flip
        hold(3'b001, 4, "R4");
        dir_fwd = 1'b0;
        tick("R5"); tick("R5"); tick("R5");
        sweep("R4");

        // R5 double flip restarts the window
        hold(3'b011, 3, "R5");
        dir_fwd = 1'b1; tick("R5");
        dir_fwd = 1'b0; tick("R5"); tick("R5"); tick("R5"); tick("R5");
        dir_fwd = 1'b1; hold(3'b011, 4, "R5");

        // R2 60-degree spacing both directions
        spacing_60 = 1'b1;
        sweep("R2");
        dir_fwd = 1'b0;
        sweep("R2");
        dir_fwd = 1'b1;

        // R6 four-phase mode, both directions
        quad_mode = 1'b1;
        sweep("R6");
        dir_fwd = 1'b0;
        sweep("R6");
        dir_fwd = 1'b1; quad_mode = 1'b0; spacing_60 = 1'b0;
        hold(3'b010, 4, "R6");

        // R12 PWM routing
        for (int r = 0; r < 2; r++) begin
            pwm_bottom_only = r[0];
            for (int i = 0; i < 8; i++) begin
                pwm_gate = i[0];
                tick("R12");
            end
        end
        pwm_gate = 1'b1; pwm_bottom_only = 1'b0;

        // R11 top polarity low
        top_pol_high = 1'b0;
        sweep("R11");
        for (int i = 0; i < 6; i++) begin
            pwm_gate = i[0];
            tick("R11");
        end
        pwm_gate = 1'b1; top_pol_high = 1'b1;

        // R7 enable low
        hall_in = 3'b011;
        enable = 1'b0; tick("R7"); tick("R7"); tick("R7");
        enable = 1'b1; tick("R7"); tick("R7");

        // R10 overcurrent on both instances
        overcurrent = 1'b1;
        tick("R10"); tick("R10");
        pwm_gate = 1'b0; tick("R10");
        pwm_bottom_only = 1'b1; tick("R10");
        pwm_gate = 1'b1; pwm_bottom_only = 1'b0;
        overcurrent = 1'b0; tick("R10"); tick("R10");

        // R8 unconditional brake overrides enable, invalid code, overcurrent, blank
        brake = 1'b1; brake_full = 1'b1;
        tick("R8");
        enable = 1'b0; tick("R8");
        enable = 1'b1; overcurrent = 1'b1; tick("R8");
        overcurrent = 1'b0; hold(3'b000, 4, "R8");
        dir_fwd = 1'b0; tick("R8"); tick("R8");
        top_pol_high = 1'b0; tick("R8"); tick("R8");
        top_pol_high = 1'b1;

        // R9 PWM brake
        brake_full = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pwm_gate = i[0];
            tick("R9");
        end
        pwm_gate = 1'b1;
        brake = 1'b0; brake_full = 1'b1;
        hold(3'b001, 5, "R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule